// File: doc/BRIEF.md
# Three-State Sequential Phase-Frequency Detector

This block compares the rising edges of two synchronous single-bit inputs: a signal input and a comparison input, the latter normally the block's own oscillator output fed back. It drives a two-bit pump command that means drive-high, drive-low or float. The command is the digital form of a charge-pump output that a separate loop filter integrates. A drive-high pulse starts on each signal edge and ends on the matching comparison edge. A drive-low pulse works the other way round. When the edges coincide the pump floats and the filter keeps its value.

Both inputs are sampled on a fast system clock, and rising edges are found inside the block. An optional per-input qualifier rejects a second rising edge that follows the last accepted one too closely. This guards against chatter on slow or noisy edges, which would otherwise count as an extra cycle and push the loop the wrong way. The block also gives a phase flag that is high while the pump is active, and a lock flag that sets after a run of well-aligned signal edges.

Top module: `pfd_seq_detector`

## Requirements
- R1: Only accepted rising edges change the pump state; falling edges and input duty cycle have no effect on any output.
- R2: When signal edges arrive at a higher rate than comparison edges, the pump never drives low and drives high (code 2'b10) for more than half of the cycles.
- R3: When comparison edges arrive at a higher rate than signal edges, the pump never drives high and drives low (code 2'b01) for more than half of the cycles.
- R4: At equal rates, a signal edge leading the comparison edge by N clocks gives exactly N cycles of 2'b10 per period, and a comparison lead of N gives N cycles of 2'b01. An input edge sampled at clock k shows on pump_o after clock k.
- R5: Rising edges accepted in the same clock on both inputs leave the pump floating (2'b00).
- R6: Pump codes are 2'b10 drive-high, 2'b01 drive-low and 2'b00 float. Code 2'b11 never appears, because a pending up and a pending down cancel in the same clock.
- R7: A pending up or down state is held until an edge arrives on the other input. Further edges on the same input are absorbed, so one extra or missing edge shows up as a whole extra pump pulse.
- R8: phase_o is high exactly when pump_o is not float.
- R9: With qual_win_i = W > 0, a rising edge that comes W clocks or fewer after the last accepted edge on the same input is ignored. W = 0 accepts every rising edge.
- R10: lock_o sets once LOCK_EDGES signal edges are accepted with no pump pulse longer than LOCK_TOL cycles. A longer pulse clears it on the next clock.
- R11: A synchronous active-low reset sets the pump to float, clears phase_o and lock_o, and makes the next rising edge on each input acceptable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Synchronous active-low reset |
| sig_i | input | 1 | Signal input, synchronous to clk_i |
| cmp_i | input | 1 | Comparison input (oscillator feedback), synchronous to clk_i |
| qual_win_i | input | WIN_W | Minimum edge spacing in clocks; 0 disables the qualifier |
| pump_o | output | 2 | Pump command: 10 drive-high, 01 drive-low, 00 float |
| phase_o | output | 1 | High while the inputs are out of alignment |
| lock_o | output | 1 | Lock indication |

## Verification
The assertions assume that both inputs are already synchronous to clk_i and that qual_win_i changes only while the block is in reset or idle. The stimulus drives every input on the falling clock edge and changes the window only between scenarios, each of which starts with a reset. The properties on held and cancelled states, and on lock clearing, need no assumption on edge spacing. The bench still covers same-clock edges, single-cycle glitches inside a pending pulse, and rates that differ in both directions, so that every branch of the pump logic is exercised.

// File: rtl/pfd_pkg.sv
// Shared definitions for the sequential phase-frequency detector.
// Assumes: pump command is two bits, one per direction.
package pfd_pkg;
    typedef enum logic [1:0] {
        PUMP_FLOAT = 2'b00,
        PUMP_DOWN  = 2'b01,
        PUMP_UP    = 2'b10
    } pump_e;

    localparam int unsigned N_INPUTS = 2;
    localparam int unsigned IDX_CMP  = 0;
    localparam int unsigned IDX_SIG  = 1;
endpackage

// File: rtl/pfd_edge_qual.sv
// Rising-edge detector with a minimum-spacing qualifier.
// Does: flags a rising edge on din_i, unless it comes win_i clocks or
// fewer after the last accepted edge. win_i == 0 accepts every edge.
// Assumes: din_i is synchronous to clk_i; win_i stable during use.
module pfd_edge_qual #(
    parameter int unsigned WIN_W = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             din_i,
    input  logic [WIN_W-1:0] win_i,
    output logic             acc_o
);
    localparam int unsigned GAP_W = WIN_W + 1;
    localparam logic [GAP_W-1:0] GAP_MAX = '1;
    localparam logic [GAP_W-1:0] GAP_ONE = GAP_W'(1);

    logic             prev_q;
    logic [GAP_W-1:0] gap_q;
    logic             rise;

    // Raw rising edge and spacing test.
    always_comb begin
        rise  = din_i & ~prev_q;
        acc_o = rise && (gap_q > {1'b0, win_i});
    end

    // Track previous input level and clocks since last accepted edge.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            prev_q <= 1'b0;
            gap_q  <= GAP_MAX;
        end else begin
            prev_q <= din_i;
            if (acc_o) begin
                gap_q <= GAP_ONE;
            end else if (gap_q != GAP_MAX) begin
                gap_q <= gap_q + GAP_ONE;
            end
        end
    end

    AST_QUAL_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
        acc_o |=> !acc_o); // R9
    AST_QUAL_RESET_GAP: assert property (@(posedge clk_i)
        !rst_ni |=> (gap_q == GAP_MAX)); // R11
endmodule

// File: rtl/pfd_pump_core.sv
// Three-state up/down core of the phase-frequency detector.
// Does: sets the up state on a signal edge and the down state on a
// comparison edge; when both would be set they cancel on the same clock.
// Assumes: event inputs are single-cycle qualified edge strobes.
module pfd_pump_core
    import pfd_pkg::*;
(
    input  logic  clk_i,
    input  logic  rst_ni,
    input  logic  up_evt_i,
    input  logic  dn_evt_i,
    output pump_e pump_o,
    output logic  active_o
);
    logic up_q, dn_q;
    logic up_n, dn_n;

    // Next state: hold pending direction, cancel when both are pending.
    always_comb begin
        up_n = up_q | up_evt_i;
        dn_n = dn_q | dn_evt_i;
        if (up_n && dn_n) begin
            up_n = 1'b0;
            dn_n = 1'b0;
        end
    end

    // State registers.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            up_q <= 1'b0;
            dn_q <= 1'b0;
        end else begin
            up_q <= up_n;
            dn_q <= dn_n;
        end
    end

    // Encode the pump command.
    always_comb begin
        unique case ({up_q, dn_q})
            2'b10:   pump_o = PUMP_UP;
            2'b01:   pump_o = PUMP_DOWN;
            default: pump_o = PUMP_FLOAT;
        endcase
        active_o = up_q | dn_q;
    end

    AST_NO_BOTH: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(up_q && dn_q)); // R6
    AST_UP_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_q && !dn_evt_i) |=> up_q); // R7
    AST_DN_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (dn_q && !up_evt_i) |=> dn_q); // R7
    AST_UP_CLEARED: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (up_q && dn_evt_i) |=> (!up_q && !dn_q)); // R4
    AST_SAME_CLOCK: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!up_q && !dn_q && up_evt_i && dn_evt_i) |=> !active_o); // R5
    AST_RESET_FLOAT: assert property (@(posedge clk_i)
        !rst_ni |=> (!up_q && !dn_q)); // R11
endmodule

// File: rtl/pfd_lock_mon.sv
// Lock monitor.
// Does: counts accepted signal edges while every pump pulse stays within
// LOCK_TOL cycles; flags lock once LOCK_EDGES edges are counted.
// Assumes: active_i is the registered pump activity.
module pfd_lock_mon #(
    parameter int unsigned LOCK_TOL   = 2,
    parameter int unsigned LOCK_EDGES = 4
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic active_i,
    input  logic sig_evt_i,
    output logic lock_o
);
    localparam int unsigned PLEN_W = $clog2(LOCK_TOL + 1) + 1;
    localparam int unsigned CNT_W  = $clog2(LOCK_EDGES + 1) + 1;
    localparam logic [PLEN_W-1:0] PLEN_SAT = PLEN_W'(LOCK_TOL);
    localparam logic [CNT_W-1:0]  CNT_TOP  = CNT_W'(LOCK_EDGES);

    logic [PLEN_W-1:0] plen_q;
    logic [CNT_W-1:0]  cnt_q;
    logic              too_long;

    // A pulse is too long once it goes past LOCK_TOL cycles.
    always_comb begin
        too_long = active_i && (plen_q >= PLEN_SAT);
        lock_o   = (cnt_q == CNT_TOP);
    end

    // Pulse-length counter, saturating at the tolerance.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            plen_q <= '0;
        end else if (!active_i) begin
            plen_q <= '0;
        end else if (plen_q != PLEN_SAT) begin
            plen_q <= plen_q + 1'b1;
        end
    end

    // Aligned-edge counter.
    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            cnt_q <= '0;
        end else if (too_long) begin
            cnt_q <= '0;
        end else if (sig_evt_i && (cnt_q != CNT_TOP)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    AST_LOCK_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
        too_long |=> !lock_o); // R10
    AST_LOCK_RISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!lock_o && !sig_evt_i) |=> !lock_o); // R10
endmodule

// File: rtl/pfd_seq_detector.sv
// Top of the three-state sequential phase-frequency detector.
// Does: qualifies rising edges of both inputs, runs the up/down core,
// and derives phase and lock flags.
// Assumes: sig_i and cmp_i are synchronous to clk_i; qual_win_i changes
// only in reset or while both inputs are idle.
module pfd_seq_detector
    import pfd_pkg::*;
#(
    parameter int unsigned WIN_W      = 4,
    parameter int unsigned LOCK_TOL   = 2,
    parameter int unsigned LOCK_EDGES = 4
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic             sig_i,
    input  logic             cmp_i,
    input  logic [WIN_W-1:0] qual_win_i,
    output logic [1:0]       pump_o,
    output logic             phase_o,
    output logic             lock_o
);
    logic [N_INPUTS-1:0] din;
    logic [N_INPUTS-1:0] evt;
    pump_e               pump;
    logic                active;

    // Gather the inputs into one vector for the qualifiers.
    always_comb begin
        din          = '0;
        din[IDX_CMP] = cmp_i;
        din[IDX_SIG] = sig_i;
    end

    for (genvar g = 0; g < N_INPUTS; g++) begin : g_qual
        pfd_edge_qual #(
            .WIN_W (WIN_W)
        ) qual_i (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .din_i  (din[g]),
            .win_i  (qual_win_i),
            .acc_o  (evt[g])
        );
    end

    pfd_pump_core core_i (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .up_evt_i (evt[IDX_SIG]),
        .dn_evt_i (evt[IDX_CMP]),
        .pump_o   (pump),
        .active_o (active)
    );

    pfd_lock_mon #(
        .LOCK_TOL   (LOCK_TOL),
        .LOCK_EDGES (LOCK_EDGES)
    ) lock_i (
        .clk_i     (clk_i),
        .rst_ni    (rst_ni),
        .active_i  (active),
        .sig_evt_i (evt[IDX_SIG]),
        .lock_o    (lock_o)
    );

    // Drive the output ports.
    always_comb begin
        pump_o  = pump;
        phase_o = active;
    end

    AST_PUMP_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
        pump_o != 2'b11); // R6
    AST_RESET_OUT: assert property (@(posedge clk_i)
        !rst_ni |=> (!phase_o && !lock_o)); // R11
endmodule

// File: tb/pfd_seq_detector_tb_top.sv
// Bench for pfd_seq_detector: behavioural per-cycle model plus directed
// window checks.
module pfd_seq_detector_tb_top;
    localparam int WIN_W = 4;
    localparam int TOL   = 2;
    localparam int EDGES = 4;
    localparam int CAP   = 1000000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             sig = 1'b0;
    logic             cmp = 1'b0;
    logic [WIN_W-1:0] win = '0;
    logic [1:0]       pump;
    logic             phase;
    logic             lock;

    int    n_tests = 0;
    int    n_fail  = 0;
    string cur_tag = "R11";
    int    cnt_up, cnt_dn, cnt_flt;

    // Model state.
    int m_ps, m_pc, m_gs, m_gc, m_up, m_dn, m_plen, m_cnt;

    always #2 clk = ~clk;

    pfd_seq_detector #(.WIN_W(WIN_W), .LOCK_TOL(TOL), .LOCK_EDGES(EDGES)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .sig_i(sig), .cmp_i(cmp),
        .qual_win_i(win), .pump_o(pump), .phase_o(phase), .lock_o(lock)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Reference model, advanced on every rising clock edge.
    always @(posedge clk) begin
        int rs, rc, as_, ac, act, bad, nu, nd;
        if (!rst_n) begin
            m_ps = 0; m_pc = 0; m_gs = CAP; m_gc = CAP;
            m_up = 0; m_dn = 0; m_plen = 0; m_cnt = 0;
        end else begin
            rs  = (sig && !m_ps) ? 1 : 0;
            rc  = (cmp && !m_pc) ? 1 : 0;
            as_ = (rs && m_gs > int'(win)) ? 1 : 0;
            ac  = (rc && m_gc > int'(win)) ? 1 : 0;
            m_gs = as_ ? 1 : ((m_gs < CAP) ? m_gs + 1 : CAP);
            m_gc = ac  ? 1 : ((m_gc < CAP) ? m_gc + 1 : CAP);
            m_ps = sig; m_pc = cmp;
            act = (m_up || m_dn) ? 1 : 0;
            bad = (act && m_plen >= TOL) ? 1 : 0;
            m_plen = act ? m_plen + 1 : 0;
            if (bad) m_cnt = 0;
            else if (as_ && m_cnt < EDGES) m_cnt++;
            nu = (m_up || as_) ? 1 : 0;
            nd = (m_dn || ac) ? 1 : 0;
            if (nu && nd) begin m_up = 0; m_dn = 0; end
            else begin m_up = nu; m_dn = nd; end
        end
    end

    // Compare outputs with the model midway between rising edges.
    always @(negedge clk) begin
        int exp_pump;
        exp_pump = m_up ? 2 : (m_dn ? 1 : 0);
        check(int'(pump) == exp_pump, {cur_tag, " pump (R6)"}, int'(pump), exp_pump);
        check(int'(phase) == ((exp_pump != 0) ? 1 : 0), "R8 phase", int'(phase), (exp_pump != 0) ? 1 : 0);
        check(int'(lock) == ((m_cnt == EDGES) ? 1 : 0), {cur_tag, " lock (R10)"}, int'(lock), (m_cnt == EDGES) ? 1 : 0);
    end

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0; sig = 1'b0; cmp = 1'b0;
        repeat (3) @(negedge clk);
        check(pump == 2'b00 && !phase && !lock, "R11 reset state", {pump, phase, lock}, 0);
        rst_n = 1'b1;
    endtask

    // Drive two square waves; count pump codes in the second half.
    task automatic run(input int ps, input int hs, input int pc, input int hc,
                       input int off, input int glitch, input int n, input string tag);
        cur_tag = tag;
        cnt_up = 0; cnt_dn = 0; cnt_flt = 0;
        for (int i = 0; i < n; i++) begin
            int ts, tc;
            @(negedge clk);
            if (i >= n / 2) begin
                if (pump == 2'b10) cnt_up++;
                else if (pump == 2'b01) cnt_dn++;
                else cnt_flt++;
            end
            ts  = i % ps;
            tc  = (i + pc * 1000 - off) % pc;
            sig = (ts < hs) && (ts != glitch);
            cmp = (tc < hc);
        end
    endtask

    initial begin
        win = '0;
        do_reset();

        // R5 / R10: aligned, equal rate.
        run(20, 10, 20, 10, 0, -1, 200, "R5");
        check(cnt_flt == 100, "R5 aligned float count", cnt_flt, 100);
        check(lock == 1'b1, "R10 lock after aligned edges", lock, 1);

        // R4: signal leads by 3.
        do_reset();
        run(20, 10, 20, 10, 3, -1, 200, "R4");
        check(cnt_up == 15 && cnt_dn == 0, "R4 up pulse length", cnt_up, 15);
        check(lock == 1'b0, "R10 lock cleared by long pulse", lock, 0);

        // R4: comparison leads by 2 (within tolerance, lock sets).
        do_reset();
        run(20, 10, 20, 10, -2, -1, 200, "R4");
        check(cnt_dn == 10 && cnt_up == 0, "R4 down pulse length", cnt_dn, 10);
        check(lock == 1'b1, "R10 lock with short pulses", lock, 1);

        // R2: signal faster.
        do_reset();
        run(14, 7, 20, 10, 0, -1, 560, "R2");
        check(cnt_dn == 0, "R2 never drives low", cnt_dn, 0);
        check(cnt_up > 140, "R2 mostly drives high", cnt_up, 141);

        // R3: comparison faster.
        do_reset();
        run(20, 10, 14, 7, 0, -1, 560, "R3");
        check(cnt_up == 0, "R3 never drives high", cnt_up, 0);
        check(cnt_dn > 140, "R3 mostly drives low", cnt_dn, 141);

        // R1: different duty cycles, aligned rising edges.
        do_reset();
        run(20, 4, 20, 16, 0, -1, 200, "R1");
        check(cnt_flt == 100, "R1 falling edges ignored", cnt_flt, 100);

        // R7: extra signal edge inside a pending up pulse is absorbed.
        do_reset();
        run(20, 10, 20, 10, 6, 2, 200, "R7");
        check(cnt_up == 30, "R7 extra edge absorbed", cnt_up, 30);

        // R9: chatter right after an aligned edge, qualifier off.
        do_reset();
        run(20, 10, 20, 10, 0, 2, 200, "R9");
        check(cnt_up > 0, "R9 chatter counted with window 0", cnt_up, 1);

        // R9: same chatter, window 4 rejects it.
        @(negedge clk); rst_n = 1'b0; win = 4'd4;
        do_reset();
        run(20, 10, 20, 10, 0, 2, 200, "R9");
        check(cnt_flt == 100, "R9 chatter rejected by window", cnt_flt, 100);

        // R11: reset in the middle of a pending pulse.
        win = '0;
        do_reset();
        cur_tag = "R11";
        @(negedge clk); sig = 1'b1;
        repeat (2) @(negedge clk);
        check(pump == 2'b10, "R11 pending before reset", pump, 2);
        rst_n = 1'b0;
        @(negedge clk);
        check(pump == 2'b00 && !phase, "R11 reset clears pending", pump, 0);
        rst_n = 1'b1; sig = 1'b0;
        repeat (4) @(negedge clk);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    // Watchdog.
    initial begin
        repeat (150000) @(posedge clk);
        n_tests++;
        n_fail++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule